// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits between a host register interface and a byte-addressed packet memory. It lets the host move a block of data through one data port instead of addressing the memory directly. The host loads a 16-bit start address and a 16-bit byte count one byte at a time. It then reads or writes the data port repeatedly. Each data-port strobe moves 1, 2 or 4 bytes at the current address. On the same clock edge the address advances and the count drops by the number of bytes moved.

The address wraps back to the ring start page when it lands on the ring stop page. When the count runs out, a sticky completion flag is raised. A remote-read or remote-write command issued while the count is already zero raises the flag at once. Only the low prom region and the packet-buffer window are reachable. Reads elsewhere return all ones, and writes elsewhere never reach the memory.

A two-state machine tracks whether bytes remain:
- `ST_EMPTY`: the count is zero.
- `ST_PENDING`: the count is non-zero.

It has four transitions:
- LOAD: a count write leaves a non-zero value, so `ST_EMPTY` goes to `ST_PENDING`.
- RELOAD: a count write leaves a non-zero value while already in `ST_PENDING`, so the state stays `ST_PENDING`.
- CLEAR: a count write leaves zero, so `ST_PENDING` goes to `ST_EMPTY`.
- EXHAUST: an access whose size covers the remaining count, so `ST_PENDING` goes to `ST_EMPTY`.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the address, the count and the configuration byte read as 0. The ring start page reads 0x40, the ring stop page reads 0x80, and `dma_done` is 0.
- R2: Register writes update one byte at a time, and the other byte keeps its value. The `reg_sel` codes are: 0 address low, 1 address high, 2 count low, 3 count high, 4 ring start page, 5 ring stop page, 6 configuration, 7 status. Each register reads back on `reg_rdata` under the same code.
- R3: With configuration bit 0 clear and `dp_long` low, a data-port access moves one byte. That byte appears on `dp_rdata[7:0]`, the address rises by 1 and the count drops by 1.
- R4: With configuration bit 0 set and `dp_long` low, an access moves a little-endian 16-bit word at the address with its bit 0 forced to 0. The address register still rises by 2 from its unaligned value, and the count drops by 2.
- R5: With `dp_long` high, an access moves 4 bytes little-endian, at the address with bit 0 forced to 0, whatever the configuration bit says. The address rises by 4 and the count drops by 4.
- R6: If the stepped address equals the ring stop page times 256, the address is reloaded with the ring start page times 256.
- R7: If the count is less than or equal to the access size, the count becomes 0 and `dma_done` is set. The flag reads as bit 6 (0x40) of the status register. Otherwise the count drops by the size.
- R8: A data-port write while the count is 0 is ignored. No byte lane is written, and the address, the count and `dma_done` are unchanged.
- R9: A command write with bit 0 (halt) clear and bit 3 (remote read) or bit 4 (remote write) set raises `dma_done` if the count is 0. With halt set, or with a non-zero count, it has no effect.
- R10: Only addresses below 32, and addresses from 0x4000 up to but not including 0x8000, are valid. An invalid read returns all ones across the access width. An invalid write enables no byte lane. Both still step the address and the count.
- R11: Writing the status register with bit 6 set clears `dma_done`. If an exhausting access falls in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register readback byte, combinational |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_long | input | 1 | Selects a 4-byte access |
| dp_wdata | input | 32 | Data-port write data, little-endian |
| dp_rdata | output | 32 | Data-port read data, combinational |
| mem_addr | output | 16 | Memory byte address of lane 0 |
| mem_wbe | output | 4 | Memory byte-lane write enables |
| mem_wdata | output | 32 | Memory write data, lane i at mem_addr+i |
| mem_rdata | input | 32 | Memory read data, lane i from mem_addr+i |
| dma_done | output | 1 | Sticky remote-DMA-complete flag |

## Verification
Two functions can fall in the same cycle: an access that exhausts the count, which sets the completion flag, and a status write that clears that flag. The bench provokes this by loading a count of 1 and then driving a byte read together with a status write carrying bit 6. It then reads the status register back and requires the flag to stay set. A second status write, with no access, must then clear the flag. This shows that the first result came from the set-over-clear priority and not from a stuck flag.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int LANES = 4;

    typedef enum logic [2:0] {
        SEL_ADDR_LO    = 3'd0,
        SEL_ADDR_HI    = 3'd1,
        SEL_CNT_LO     = 3'd2,
        SEL_CNT_HI     = 3'd3,
        SEL_RING_START = 3'd4,
        SEL_RING_STOP  = 3'd5,
        SEL_CFG        = 3'd6,
        SEL_STATUS     = 3'd7
    } reg_sel_e;

    typedef enum logic {
        ST_EMPTY   = 1'b0,
        ST_PENDING = 1'b1
    } eng_state_e;

    localparam int CMD_HALT_BIT    = 0;
    localparam int CMD_RREAD_BIT   = 3;
    localparam int CMD_RWRITE_BIT  = 4;
    localparam int STATUS_DONE_BIT = 6;
    localparam int CFG_WIDE_BIT    = 0;

endpackage

// File: rtl/rdma_step.sv
module rdma_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0]   cur_addr,
    input  logic [AW-1:0]   cur_cnt,
    input  logic [2:0]      nbytes,
    input  logic [AW-9:0]   ring_start_pg,
    input  logic [AW-9:0]   ring_stop_pg,
    output logic [AW-1:0]   nxt_addr,
    output logic [AW-1:0]   nxt_cnt,
    output logic            exhaust
);
    localparam int PAD = AW - 3;

    logic [AW-1:0] size_ext;
    logic [AW-1:0] stepped;
    logic [AW-1:0] stop_addr;
    logic [AW-1:0] start_addr;

    always_comb begin
        size_ext   = {{PAD{1'b0}}, nbytes};
        stepped    = cur_addr + size_ext;
        stop_addr  = {ring_stop_pg, 8'h00};
        start_addr = {ring_start_pg, 8'h00};
        nxt_addr   = (stepped == stop_addr) ? start_addr : stepped;
        exhaust    = (cur_cnt <= size_ext);
        nxt_cnt    = exhaust ? '0 : (cur_cnt - size_ext);
    end
endmodule

// File: rtl/rdma_lane.sv
module rdma_lane
    import rdma_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            PROM_LIMIT = 32,
    parameter logic [AW-1:0] WIN_BASE   = 16'h4000,
    parameter logic [AW-1:0] WIN_END    = 16'h8000
) (
    input  logic [AW-1:0]        cur_addr,
    input  logic [2:0]           nbytes,
    input  logic                 wr_go,
    input  logic [8*LANES-1:0]   dp_wdata,
    input  logic [8*LANES-1:0]   mem_rdata,
    output logic [AW-1:0]        mem_addr,
    output logic [LANES-1:0]     mem_wbe,
    output logic [8*LANES-1:0]   mem_wdata,
    output logic [8*LANES-1:0]   rd_data
);
    localparam logic [AW-1:0] PROM_TOP = AW'(PROM_LIMIT);

    logic [AW-1:0] base;
    logic          in_win;

    always_comb begin
        base   = (nbytes != 3'd1) ? {cur_addr[AW-1:1], 1'b0} : cur_addr;
        in_win = (base < PROM_TOP) || ((base >= WIN_BASE) && (base < WIN_END));
    end

    assign mem_addr  = base;
    assign mem_wdata = dp_wdata;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic lane_on;
        assign lane_on = (i < int'(nbytes));
        assign mem_wbe[i] = wr_go && in_win && lane_on;
        assign rd_data[8*i +: 8] = !lane_on ? 8'h00 :
                                   (in_win ? mem_rdata[8*i +: 8] : 8'hFF);
    end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_load,
    input  logic cnt_load_nz,
    input  logic access,
    input  logic exhaust,
    input  logic zero_cmd,
    input  logic done_clr,
    output logic pending,
    output logic done
);
    eng_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (cnt_load && cnt_load_nz) state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (cnt_load)                state_d = cnt_load_nz ? ST_PENDING : ST_EMPTY;
                else if (access && exhaust)  state_d = ST_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == ST_PENDING);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              done <= 1'b0;
        else if ((access && exhaust) || zero_cmd) done <= 1'b1;
        else if (done_clr)                       done <= 1'b0;
    end

    a_r11_clear_yields: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !(access && exhaust) && !zero_cmd) |=> !done);
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int            AW           = 16,
    parameter int            PROM_LIMIT   = 32,
    parameter logic [AW-1:0] WIN_BASE     = 16'h4000,
    parameter logic [AW-1:0] WIN_END      = 16'h8000,
    parameter logic [AW-9:0] START_PG_RST = 8'h40,
    parameter logic [AW-9:0] STOP_PG_RST  = 8'h80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        cmd_wr,
    input  logic [7:0]  cmd_data,
    input  logic        dp_rd,
    input  logic        dp_wr,
    input  logic        dp_long,
    input  logic [31:0] dp_wdata,
    output logic [31:0] dp_rdata,
    output logic [15:0] mem_addr,
    output logic [3:0]  mem_wbe,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        dma_done
);
    localparam int HI_W = AW - 8;

    reg_sel_e        sel;
    logic [AW-1:0]   addr_q, cnt_q;
    logic [HI_W-1:0] start_pg_q, stop_pg_q;
    logic [7:0]      cfg_q;
    logic [2:0]      nbytes;
    logic            pending, access, wr_go, exhaust;
    logic            cnt_wr, addr_wr, zero_cmd, done_clr;
    logic [AW-1:0]   cnt_load_val, nxt_addr, nxt_cnt;

    always_comb begin
        sel      = reg_sel_e'(reg_sel);
        nbytes   = dp_long ? 3'd4 : (cfg_q[CFG_WIDE_BIT] ? 3'd2 : 3'd1);
        wr_go    = dp_wr && !dp_rd && pending;
        access   = dp_rd || wr_go;
        cnt_wr   = reg_wr && ((sel == SEL_CNT_LO) || (sel == SEL_CNT_HI));
        addr_wr  = reg_wr && ((sel == SEL_ADDR_LO) || (sel == SEL_ADDR_HI));
        done_clr = reg_wr && (sel == SEL_STATUS) && reg_wdata[STATUS_DONE_BIT];
        zero_cmd = cmd_wr && !cmd_data[CMD_HALT_BIT] &&
                   (cmd_data[CMD_RREAD_BIT] || cmd_data[CMD_RWRITE_BIT]) &&
                   (cnt_q == '0);
        cnt_load_val = (sel == SEL_CNT_LO) ? {cnt_q[AW-1:8], reg_wdata}
                                           : {reg_wdata[HI_W-1:0], cnt_q[7:0]};
    end

    rdma_step #(.AW(AW)) u_step (
        .cur_addr      (addr_q),
        .cur_cnt       (cnt_q),
        .nbytes        (nbytes),
        .ring_start_pg (start_pg_q),
        .ring_stop_pg  (stop_pg_q),
        .nxt_addr      (nxt_addr),
        .nxt_cnt       (nxt_cnt),
        .exhaust       (exhaust)
    );

    rdma_lane #(
        .AW(AW), .PROM_LIMIT(PROM_LIMIT), .WIN_BASE(WIN_BASE), .WIN_END(WIN_END)
    ) u_lane (
        .cur_addr  (addr_q),
        .nbytes    (nbytes),
        .wr_go     (wr_go),
        .dp_wdata  (dp_wdata),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wbe   (mem_wbe),
        .mem_wdata (mem_wdata),
        .rd_data   (dp_rdata)
    );

    rdma_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_load    (cnt_wr),
        .cnt_load_nz (cnt_load_val != '0),
        .access      (access),
        .exhaust     (exhaust),
        .zero_cmd    (zero_cmd),
        .done_clr    (done_clr),
        .pending     (pending),
        .done        (dma_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            addr_q <= '0;
        else if (reg_wr && sel == SEL_ADDR_LO) addr_q[7:0] <= reg_wdata;
        else if (reg_wr && sel == SEL_ADDR_HI) addr_q[AW-1:8] <= reg_wdata[HI_W-1:0];
        else if (access)                       addr_q <= nxt_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= cnt_load_val;
        else if (access) cnt_q <= nxt_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pg_q <= START_PG_RST;
            stop_pg_q  <= STOP_PG_RST;
            cfg_q      <= 8'h00;
        end else if (reg_wr) begin
            if (sel == SEL_RING_START) start_pg_q <= reg_wdata[HI_W-1:0];
            if (sel == SEL_RING_STOP)  stop_pg_q  <= reg_wdata[HI_W-1:0];
            if (sel == SEL_CFG)        cfg_q      <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        unique case (sel)
            SEL_ADDR_LO:    reg_rdata = addr_q[7:0];
            SEL_ADDR_HI:    reg_rdata = 8'(addr_q[AW-1:8]);
            SEL_CNT_LO:     reg_rdata = cnt_q[7:0];
            SEL_CNT_HI:     reg_rdata = 8'(cnt_q[AW-1:8]);
            SEL_RING_START: reg_rdata = 8'(start_pg_q);
            SEL_RING_STOP:  reg_rdata = 8'(stop_pg_q);
            SEL_CFG:        reg_rdata = cfg_q;
            SEL_STATUS:     reg_rdata[STATUS_DONE_BIT] = dma_done;
        endcase
    end

    logic [AW-1:0] size_ext;
    assign size_ext = {{(AW-3){1'b0}}, nbytes};

    a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !cnt_wr && (cnt_q > size_ext)) |=> (cnt_q == $past(cnt_q) - $past(size_ext)));

    a_r7_done_on_exhaust: assert property (@(posedge clk) disable iff (!rst_n)
        (access && (cnt_q <= size_ext)) |=> dma_done);

    a_r6_never_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !reg_wr && (start_pg_q != stop_pg_q)) |=> (addr_q != {stop_pg_q, 8'h00}));

    a_r8_empty_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr && !dp_rd && (cnt_q == '0)) |-> (mem_wbe == 4'b0000));

    a_r4_even_lane_base: assert property (@(posedge clk) disable iff (!rst_n)
        ((dp_rd || dp_wr) && (nbytes != 3'd1)) |-> !mem_addr[0]);

    a_r8_state_follows_count: assert property (@(posedge clk) disable iff (!rst_n)
        pending == (cnt_q != '0));
endmodule

// File: tb/rdma_port_engine_test.sv
`timescale 1ns/1ps
module rdma_port_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_data = 8'h00;
    logic        dp_rd = 1'b0, dp_wr = 1'b0, dp_long = 1'b0;
    logic [31:0] dp_wdata = 32'h0;
    logic [31:0] dp_rdata;
    logic [15:0] mem_addr;
    logic [3:0]  mem_wbe;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        dma_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] bmem [256];
    logic [7:0] a0, a1, a2, a3;

    always #2.5 clk = ~clk;

    assign a0 = mem_addr[7:0];
    assign a1 = a0 + 8'd1;
    assign a2 = a0 + 8'd2;
    assign a3 = a0 + 8'd3;
    assign mem_rdata = {bmem[a3], bmem[a2], bmem[a1], bmem[a0]};

    always @(posedge clk) begin
        if (mem_wbe[0]) bmem[a0] <= mem_wdata[7:0];
        if (mem_wbe[1]) bmem[a1] <= mem_wdata[15:8];
        if (mem_wbe[2]) bmem[a2] <= mem_wdata[23:16];
        if (mem_wbe[3]) bmem[a3] <= mem_wdata[31:24];
    end

    rdma_port_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr),
        .cmd_data(cmd_data), .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_long(dp_long),
        .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .mem_addr(mem_addr),
        .mem_wbe(mem_wbe), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dma_done(dma_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic set16(input logic [2:0] lo_sel, input logic [15:0] v);
        wr_reg(lo_sel, v[7:0]);
        wr_reg(lo_sel + 3'd1, v[15:8]);
    endtask

    task automatic get16(input logic [2:0] lo_sel, output logic [15:0] v);
        logic [7:0] l, h;
        rd_reg(lo_sel, l);
        rd_reg(lo_sel + 3'd1, h);
        v = {h, l};
    endtask

    task automatic dp_go(input logic rd, input logic wr, input logic lng,
                         input logic [31:0] wd, output logic [31:0] rdv,
                         output logic [3:0] wbe, output logic [15:0] ma);
        @(negedge clk);
        dp_rd = rd; dp_wr = wr; dp_long = lng; dp_wdata = wd;
        #1 rdv = dp_rdata; wbe = mem_wbe; ma = mem_addr;
        @(negedge clk);
        dp_rd = 1'b0; dp_wr = 1'b0; dp_long = 1'b0;
    endtask

    task automatic clear_done();
        wr_reg(3'd7, 8'h40);
    endtask

    task automatic t_reset();
        logic [15:0] v; logic [7:0] b;
        get16(3'd0, v); chk("R1 addr", 32'(v), 32'h0);
        get16(3'd2, v); chk("R1 count", 32'(v), 32'h0);
        rd_reg(3'd4, b); chk("R1 ring start", 32'(b), 32'h40);
        rd_reg(3'd5, b); chk("R1 ring stop", 32'(b), 32'h80);
        rd_reg(3'd6, b); chk("R1 cfg", 32'(b), 32'h0);
        chk("R1 done", 32'(dma_done), 32'h0);
    endtask

    task automatic t_halves();
        logic [15:0] v;
        set16(3'd0, 16'h4034);
        get16(3'd0, v); chk("R2 addr load", 32'(v), 32'h4034);
        wr_reg(3'd0, 8'h10);
        get16(3'd0, v); chk("R2 addr low only", 32'(v), 32'h4010);
        set16(3'd2, 16'h0105);
        wr_reg(3'd3, 8'h00);
        get16(3'd2, v); chk("R2 count high only", 32'(v), 32'h0005);
    endtask

    task automatic t_byte();
        logic [31:0] r; logic [3:0] w; logic [15:0] m, v;
        wr_reg(3'd6, 8'h00);
        set16(3'd0, 16'h4010); set16(3'd2, 16'd3);
        dp_go(1, 0, 0, 0, r, w, m);
        chk("R3 byte data", r, {24'h0, bmem[8'h10]});
        get16(3'd0, v); chk("R3 addr step", 32'(v), 32'h4011);
        get16(3'd2, v); chk("R3 count step", 32'(v), 32'd2);
    endtask

    task automatic t_word();
        logic [31:0] r; logic [3:0] w; logic [15:0] m, v;
        wr_reg(3'd6, 8'h01);
        set16(3'd0, 16'h4021); set16(3'd2, 16'd10);
        dp_go(1, 0, 0, 0, r, w, m);
        chk("R4 word data", r, {16'h0, bmem[8'h21], bmem[8'h20]});
        chk("R4 even base", 32'(m), 32'h4020);
        get16(3'd0, v); chk("R4 addr step", 32'(v), 32'h4023);
        get16(3'd2, v); chk("R4 count step", 32'(v), 32'd8);
        set16(3'd0, 16'h4030);
        dp_go(0, 1, 0, 32'h0000BEEF, r, w, m);
        chk("R4 word lanes", 32'(w), 32'h3);
        chk("R4 word write lo", 32'(bmem[8'h30]), 32'hEF);
        chk("R4 word write hi", 32'(bmem[8'h31]), 32'hBE);
    endtask

    task automatic t_long();
        logic [31:0] r; logic [3:0] w; logic [15:0] m, v;
        wr_reg(3'd6, 8'h00);
        set16(3'd0, 16'h4040); set16(3'd2, 16'd10);
        dp_go(1, 0, 1, 0, r, w, m);
        chk("R5 long data", r, {bmem[8'h43], bmem[8'h42], bmem[8'h41], bmem[8'h40]});
        get16(3'd0, v); chk("R5 addr step", 32'(v), 32'h4044);
        get16(3'd2, v); chk("R5 count step", 32'(v), 32'd6);
    endtask

    task automatic t_wrap();
        logic [31:0] r; logic [3:0] w; logic [15:0] m, v;
        wr_reg(3'd4, 8'h46); wr_reg(3'd5, 8'h48);
        set16(3'd0, 16'h47FF); set16(3'd2, 16'd9);
        dp_go(1, 0, 0, 0, r, w, m);
        get16(3'd0, v); chk("R6 byte wrap", 32'(v), 32'h4600);
        set16(3'd0, 16'h47FC);
        dp_go(1, 0, 1, 0, r, w, m);
        get16(3'd0, v); chk("R6 long wrap", 32'(v), 32'h4600);
        set16(3'd0, 16'h47FA);
        dp_go(1, 0, 1, 0, r, w, m);
        get16(3'd0, v); chk("R6 no wrap short of stop", 32'(v), 32'h47FE);
        wr_reg(3'd4, 8'h40); wr_reg(3'd5, 8'h80);
    endtask

    task automatic t_exhaust();
        logic [31:0] r; logic [3:0] w; logic [15:0] m, v; logic [7:0] b;
        clear_done();
        wr_reg(3'd6, 8'h01);
        set16(3'd0, 16'h4060); set16(3'd2, 16'd3);
        dp_go(1, 0, 0, 0, r, w, m);
        get16(3'd2, v); chk("R7 count above size", 32'(v), 32'd1);
        chk("R7 done not yet", 32'(dma_done), 32'h0);
        dp_go(1, 0, 0, 0, r, w, m);
        get16(3'd2, v); chk("R7 count floored", 32'(v), 32'd0);
        chk("R7 done set", 32'(dma_done), 32'h1);
        rd_reg(3'd7, b); chk("R7 status bit", 32'(b), 32'h40);
        wr_reg(3'd6, 8'h00);
    endtask

    task automatic t_zero_write();
        logic [31:0] r; logic [3:0] w; logic [15:0] m, v; logic [7:0] keep;
        clear_done();
        set16(3'd0, 16'h4050); set16(3'd2, 16'd0);
        keep = bmem[8'h50];
        dp_go(0, 1, 0, 32'h77, r, w, m);
        chk("R8 no lanes", 32'(w), 32'h0);
        chk("R8 memory kept", 32'(bmem[8'h50]), 32'(keep));
        get16(3'd0, v); chk("R8 addr kept", 32'(v), 32'h4050);
        get16(3'd2, v); chk("R8 count kept", 32'(v), 32'h0);
        chk("R8 done kept", 32'(dma_done), 32'h0);
    endtask

    task automatic do_cmd(input logic [7:0] c);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = c;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic t_zero_cmd();
        clear_done();
        set16(3'd2, 16'd0);
        do_cmd(8'h08); chk("R9 read cmd zero count", 32'(dma_done), 32'h1);
        clear_done();
        do_cmd(8'h09); chk("R9 halt suppresses", 32'(dma_done), 32'h0);
        do_cmd(8'h10); chk("R9 write cmd zero count", 32'(dma_done), 32'h1);
        clear_done();
        set16(3'd2, 16'd4);
        do_cmd(8'h08); chk("R9 nonzero count no effect", 32'(dma_done), 32'h0);
    endtask

    task automatic t_window();
        logic [31:0] r; logic [3:0] w; logic [15:0] m, v;
        wr_reg(3'd6, 8'h00);
        set16(3'd0, 16'h2000); set16(3'd2, 16'd8);
        dp_go(1, 0, 0, 0, r, w, m);
        chk("R10 invalid byte read", r, 32'h000000FF);
        get16(3'd0, v); chk("R10 addr still steps", 32'(v), 32'h2001);
        get16(3'd2, v); chk("R10 count still steps", 32'(v), 32'd7);
        set16(3'd0, 16'h8000);
        dp_go(1, 0, 1, 0, r, w, m);
        chk("R10 invalid long read", r, 32'hFFFFFFFF);
        dp_go(0, 1, 0, 32'h55, r, w, m);
        chk("R10 invalid write dropped", 32'(w), 32'h0);
        set16(3'd0, 16'h0004);
        dp_go(0, 1, 0, 32'h5A, r, w, m);
        chk("R10 low region write", 32'(w), 32'h1);
        chk("R10 low region data", 32'(bmem[8'h04]), 32'h5A);
    endtask

    task automatic t_race();
        logic [7:0] b;
        clear_done();
        wr_reg(3'd6, 8'h00);
        set16(3'd0, 16'h4070); set16(3'd2, 16'd1);
        @(negedge clk);
        dp_rd = 1'b1; reg_wr = 1'b1; reg_sel = 3'd7; reg_wdata = 8'h40;
        @(negedge clk);
        dp_rd = 1'b0; reg_wr = 1'b0;
        rd_reg(3'd7, b); chk("R11 set beats clear", 32'(b), 32'h40);
        clear_done();
        chk("R11 clear alone", 32'(dma_done), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halves();
        t_byte();
        t_word();
        t_long();
        t_wrap();
        t_exhaust();
        t_zero_write();
        t_zero_cmd();
        t_window();
        t_race();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule